// File: doc/BRIEF.md
# Programmable Clock Pulse Throttle

This block passes an input clock to an output through a gate that software controls. A small register port starts and stops the output clock. It can also load a pulse budget, so that exactly that many rising edges appear on the output before the gate closes. A budget of zero makes the clock run freely. This helps with debug and co-simulation, where logic on the output clock has to be stepped, paused and inspected.

An asynchronous trigger input can freeze a finite burst part way through. The trigger is synchronised into the input clock domain, and its rising edge closes the gate while keeping the remaining budget. A later control write either reloads the budget and starts again, or resumes from the count that is left. The remaining count and a state code can be read back at any time.

The gate enable is captured on the falling edge of the input clock, so the output never carries a shortened high phase.

Top module: `clk_throttle`

## Requirements
- R1: Reset behaviour.
  - While the asynchronous reset is low, `clk_out` stays low.
  - After reset is released, the block is in the running state (status code 1) in continuous mode, with a current count of 0.
  - `clk_out` then delivers one rising edge for every input clock cycle.
- R2: Writing register address 0 stores a new pulse budget. The write does not alter the current count or the pulse total of a burst already in progress. The new budget is used at the next start command.
- R3: A control write (address 1) with bit 0 set starts a burst.
  - It loads the stored budget N, where N is nonzero.
  - Exactly N rising edges then appear on `clk_out`.
  - The block then reports the finished state (status code 3) with a current count of 0.
- R4: A start command with a stored budget of 0 makes the output run continuously (status code 1), with one rising edge per input cycle.
- R5: Reading address 0 returns the remaining count, which falls by one for each pulse delivered in a finite burst.
- R6: A low-to-high transition on `trig_in` during a finite burst halts it.
  - Suppose the transition is applied in the cycle after start edge k+T. Pulses then stop after edge k+T+3.
  - The status becomes halted (code 2) and the count holds.
- R7: `trig_in` edges have no effect in continuous mode.
- R8: If the halt would take effect on the same edge as the burst's final pulse, the burst completes and reports finished (code 3).
- R9: A control write with bit 1 set and bit 0 clear resumes delivery from the remaining count without reloading it. A trigger level that is held high causes no new halt.
- R10: A control write with both bit 0 and bit 1 clear stops the output (status code 0) and keeps the remaining count.
- R11: The gate enable changes only while `clk_in` is low. Every high phase of `clk_out` lasts a full input high phase.
- R12: Reading address 1 returns the state in bits [1:0] (0 stopped, 1 running, 2 halted, 3 finished) and the finite-mode flag in bit 2, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous pause trigger (rising edge) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 budget, 1 control |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 1 | Read address: 0 count, 1 status |
| rd_data | output | CNT_W | Read data (combinational from address) |
| clk_out | output | 1 | Gated output clock |

## Verification
A control write that is applied before edge k takes effect at edge k. The pulses of the burst then fall on edges k+1 through k+N, and status and count are final in the cycle after the last of them. A trigger raised after edge k+T passes two synchroniser flops and one edge register, so the gate closes after edge k+T+3. The bench therefore expects min(N, T+3) pulses. The bench drives and samples on the falling edge. It clears its pulse tally right after each command edge and reads results only after a fixed window that is longer than any of these latencies. Read data is combinational, so each read is sampled shortly after its address is set.

// File: rtl/clk_throttle_pkg.sv
package clk_throttle_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_DONE = 2'd3
  } thr_state_e;

  localparam logic REG_COUNT = 1'b0;
  localparam logic REG_CTRL  = 1'b1;

  localparam int CTRL_GO_BIT     = 0;
  localparam int CTRL_RESUME_BIT = 1;

endpackage

// File: rtl/thr_rst_sync.sv
module thr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign rst_n_o = sr_q[STAGES-1];

endmodule

// File: rtl/thr_trig_detect.sv
module thr_trig_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              level;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], trig_async};
  end

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= level;
    end
  end

  assign rise_o = level & ~prev_q;

endmodule

// File: rtl/thr_pulse_ctrl.sv
module thr_pulse_ctrl
  import clk_throttle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_rise,
  output thr_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fin_o,
  output logic             ctrl_wr_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  thr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff;
  logic [CNT_W-1:0] prog_q;
  logic             fin_q, fin_d;
  logic             ctrl_wr, prog_wr, dec;
  logic             state_en, cnt_en, fin_en;

  always_comb begin
    ctrl_wr = wr_en & (wr_addr == REG_CTRL);
    prog_wr = wr_en & (wr_addr == REG_COUNT);
    dec     = (state_q == ST_RUN) & fin_q;
    cnt_eff = dec ? (cnt_q - ONE) : cnt_q;

    state_d = state_q;
    cnt_d   = cnt_eff;
    fin_d   = fin_q;

    if (ctrl_wr) begin
      if (wr_data[CTRL_GO_BIT]) begin
        state_d = ST_RUN;
        cnt_d   = prog_q;
        fin_d   = |prog_q;
      end else if (wr_data[CTRL_RESUME_BIT]) begin
        state_d = (fin_q && (cnt_eff == '0)) ? ST_DONE : ST_RUN;
      end else begin
        state_d = ST_IDLE;
      end
    end else if (dec) begin
      if (cnt_q == ONE)   state_d = ST_DONE;
      else if (trig_rise) state_d = ST_HALT;
    end

    state_en = ctrl_wr | dec;
    cnt_en   = ctrl_wr | dec;
    fin_en   = ctrl_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      prog_q  <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (fin_en)   fin_q   <= fin_d;
      if (prog_wr)  prog_q  <= wr_data;
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign fin_o     = fin_q;
  assign ctrl_wr_o = ctrl_wr;

endmodule

// File: rtl/thr_clk_gate.sv
module thr_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  output logic en_q_o,
  output logic clk_gated
);

  logic en_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_req;
  end

  assign en_q_o    = en_q;
  assign clk_gated = clk & en_q;

endmodule

// File: rtl/clk_throttle.sv
module clk_throttle
  import clk_throttle_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_in,
  input  logic             arst_n,
  input  logic             trig_in,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             clk_out
);

  logic             rst_sync_n;
  logic             trig_rise;
  thr_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             fin;
  logic             ctrl_wr;
  logic             gate_en;
  logic             run_req;

  thr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk_in),
    .arst_n  (arst_n),
    .rst_n_o (rst_sync_n)
  );

  thr_trig_detect #(.STAGES(SYNC_STAGES)) u_trig (
    .clk        (clk_in),
    .rst_n      (rst_sync_n),
    .trig_async (trig_in),
    .rise_o     (trig_rise)
  );

  thr_pulse_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk_in),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .trig_rise (trig_rise),
    .state_o   (st),
    .cnt_o     (cnt),
    .fin_o     (fin),
    .ctrl_wr_o (ctrl_wr)
  );

  assign run_req = (st == ST_RUN);

  thr_clk_gate u_gate (
    .clk       (clk_in),
    .rst_n     (rst_sync_n),
    .en_req    (run_req),
    .en_q_o    (gate_en),
    .clk_gated (clk_out)
  );

  always_comb begin
    if (rd_addr == REG_COUNT) rd_data = cnt;
    else                      rd_data = CNT_W'({fin, st});
  end

endmodule

// File: rtl/thr_checker.sv
module thr_checker
  import clk_throttle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input thr_state_e       state,
  input logic [CNT_W-1:0] cnt,
  input logic             fin,
  input logic             gate_en
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R5: without a control write the count never rises
  a_r5_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> (cnt <= $past(cnt)));

  // R6: a halted burst stays halted until software writes control
  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !ctrl_wr) |=> (state == ST_HALT));

  // R7: continuous mode never reaches the halted state
  a_r7_no_halt_continuous: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |-> (state != ST_HALT));

  // R3: a finished burst has spent its whole budget
  a_r3_done_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> (cnt == '0));

  // R11: the gate seen at a rising edge was set in the low phase from the running state
  a_r11_gate_tracks_state: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (gate_en == (state == ST_RUN)));

endmodule

bind clk_throttle thr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk_in),
  .rst_n   (rst_sync_n),
  .ctrl_wr (ctrl_wr),
  .state   (st),
  .cnt     (cnt),
  .fin     (fin),
  .gate_en (gate_en)
);

// File: tb/tb_clk_throttle.sv
`timescale 1ns/1ps
module tb_clk_throttle;

  localparam int CNT_W = 16;
  localparam int HALF  = 10;
  localparam int WIN   = 40;

  typedef struct packed {
    int n;
    int trig_at;
    int exp_pulses;
    int exp_st;
    int exp_cnt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{5,  -1, 5,   3, 0},   // R3 plain burst
    '{1,  -1, 1,   3, 0},   // R3 single pulse
    '{20,  2, 5,   2, 15},  // R6 halt mid burst
    '{4,   2, 4,   3, 0},   // R8 burst ends before halt lands
    '{0,   2, WIN, 1, 0},   // R4 R7 continuous, trigger ignored
    '{3,   0, 3,   3, 0}    // R8 halt and last pulse on same edge
  };

  logic             clk_in = 1'b0;
  logic             arst_n = 1'b0;
  logic             trig_in = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_addr = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             rd_addr = 1'b0;
  logic [CNT_W-1:0] rd_data;
  logic             clk_out;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int glitches = 0;
  bit done_flag = 0;
  realtime rise_t = 0.0;

  clk_throttle #(.CNT_W(CNT_W)) dut (
    .clk_in (clk_in), .arst_n (arst_n), .trig_in (trig_in),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data), .clk_out (clk_out)
  );

  always #(HALF) clk_in = ~clk_in;

  always @(posedge clk_out) begin
    pulses++;
    rise_t = $realtime;
  end

  always @(negedge clk_out) begin
    if ($realtime - rise_t != real'(HALF)) glitches++;
  end

  always @(negedge clk_in) begin
    #1;
    if (clk_out) glitches++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic addr, input int data);
    @(negedge clk_in);
    wr_en = 1'b1; wr_addr = addr; wr_data = CNT_W'(data);
    @(negedge clk_in);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic addr, output int val);
    rd_addr = addr;
    #1;
    val = int'(rd_data);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_in);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(2 * HALF * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int v;
    // R1 reset
    wait_cyc(3);
    chk("R1 clk_out low in reset", int'(clk_out), 0);
    arst_n = 1'b1;
    wait_cyc(6);
    rd(1'b1, v); chk("R1 status after reset", v, 1);
    rd(1'b0, v); chk("R1 count after reset", v, 0);
    pulses = 0;
    wait_cyc(10);
    chk("R1 free running pulses", pulses, 10);

    // vector table
    foreach (VECS[i]) begin
      reg_wr(1'b0, VECS[i].n);
      reg_wr(1'b1, 1);
      pulses = 0;
      for (int c = 0; c < WIN; c++) begin
        if (VECS[i].trig_at >= 0 && c == VECS[i].trig_at) trig_in = 1'b1;
        @(negedge clk_in);
      end
      chk($sformatf("R3/R6/R8 vec%0d pulses", i), pulses, VECS[i].exp_pulses);
      rd(1'b1, v);
      chk($sformatf("R12 vec%0d state", i), v & 3, VECS[i].exp_st);
      chk($sformatf("R12 vec%0d finite flag", i), (v >> 2), (VECS[i].n != 0) ? 1 : 0);
      rd(1'b0, v);
      chk($sformatf("R5 vec%0d count", i), v, VECS[i].exp_cnt);
      trig_in = 1'b0;
      wait_cyc(5);
    end

    // R9 resume with trigger held high
    reg_wr(1'b0, 20);
    reg_wr(1'b1, 1);
    for (int c = 0; c < 20; c++) begin
      if (c == 2) trig_in = 1'b1;
      @(negedge clk_in);
    end
    rd(1'b0, v); chk("R6 halted count", v, 15);
    reg_wr(1'b1, 2);
    pulses = 0;
    wait_cyc(WIN);
    chk("R9 resumed pulses", pulses, 15);
    rd(1'b1, v); chk("R9 status after resume", v & 3, 3);
    trig_in = 1'b0;
    wait_cyc(5);

    // R5 count readback and R2 budget write mid burst
    reg_wr(1'b0, 30);
    reg_wr(1'b1, 1);
    pulses = 0;
    wait_cyc(10);
    rd(1'b0, v); chk("R5 count after 10 pulses", v, 20);
    reg_wr(1'b0, 7);
    rd(1'b0, v); chk("R2 count untouched by budget write", v, 18);
    wait_cyc(WIN);
    chk("R2 burst total unchanged", pulses, 30);
    reg_wr(1'b1, 1);
    pulses = 0;
    wait_cyc(20);
    chk("R2 new budget used", pulses, 7);

    // R10 stop mid burst, then R9 resume from idle
    reg_wr(1'b0, 30);
    reg_wr(1'b1, 1);
    pulses = 0;
    wait_cyc(3);
    reg_wr(1'b1, 0);
    chk("R10 pulses before stop", pulses, 5);
    pulses = 0;
    wait_cyc(10);
    chk("R10 no pulses when stopped", pulses, 0);
    rd(1'b1, v); chk("R10 status stopped", v & 3, 0);
    rd(1'b0, v); chk("R10 count kept", v, 25);
    reg_wr(1'b1, 2);
    pulses = 0;
    wait_cyc(WIN);
    chk("R9 resume from stop", pulses, 25);

    // R11 output shape
    chk("R11 no runt or low-phase pulse", glitches, 0);
    finish_run();
  end

endmodule